// File: doc/BRIEF.md
# Handshaked Byte Shift Transfer Engine

This block moves packet bytes between a host processor and a device controller through one shared 8-bit shift register. No shift clock is used. The host drives two active-low handshake lines, transfer-in-progress and transfer-acknowledge, by writing a port-B register. While a transfer is open, every change of either line advances the engine by one byte. The engine drives a third active-low line, transfer-request, back to the host.

An auxiliary-control bit sets the direction. When the host sends, each step copies the shift register into a 16-entry capture buffer. When the transfer closes, the captured packet and its length are handed to the controller side. When the host receives, the controller first preloads a reply of 1 to 128 bytes. Each step then places the next reply byte in the shift register. Transfer-request tells the host that a reply is waiting and marks its last byte. While the link is idle, transfer-request also answers acknowledge changes as a synchronisation handshake.

Top module: `hs_shift_engine`

## Requirements
- R1: After reset, treq_n is 1, sr_irq is 0, sr_q is 0x00 and pkt_done is 0.
- R2: Writes select a register with wr_sel: 0 is port B, 1 is the shift register, 2 is auxiliary control, and 3 is unused. In port B, bit 5 is transfer-in-progress and bit 4 is acknowledge, both active low. Auxiliary bit 4 set to 1 means host-to-engine, and 0 means engine-to-host. A step happens only on a port-B write with bit 5 low where bit 5 or bit 4 differs from the previous port-B write. A repeated identical write moves nothing.
- R3: In the host-to-engine direction, each step stores the current sr_q value in the next capture buffer entry.
- R4: Steps after the 16th in one packet store nothing, and the captured length stops at 16.
- R5: In the engine-to-host direction, a step happens only while reply bytes remain. It loads the next reply byte into sr_q. A step that delivers the last byte drives treq_n to 1.
- R6: A port-B write that changes bit 5 from low to high ends the transfer. If at least one byte was captured, pkt_done pulses for one cycle with the count on pkt_len, the bytes can be read at pkt_rd_addr, and capturing restarts at entry 0.
- R7: Every step and every transfer end set sr_irq. A shift-register write (wr_sel 1) or an rd_sr strobe clears sr_irq, and setting wins over clearing.
- R8: At a transfer end, if bit 4 also changed, treq_n toggles. After that, if reply bytes are still waiting, treq_n is forced to 0.
- R9: A port-B write with bit 5 high that follows a write with bit 5 high leaves treq_n, sr_q and sr_irq unchanged.
- R10: Reply bytes are written with rpl_we, rpl_addr and rpl_data. Pulsing rpl_go with rpl_len between 1 and 128 sets the read index to 0, records the length and drives treq_n to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 port B, 1 shift register, 2 auxiliary control |
| wr_data | input | 8 | Write data |
| rd_sr | input | 1 | Host read of the shift register, clears sr_irq |
| rpl_we | input | 1 | Reply buffer write strobe |
| rpl_addr | input | 7 | Reply buffer write address |
| rpl_data | input | 8 | Reply buffer write data |
| rpl_go | input | 1 | Arm a reply of rpl_len bytes |
| rpl_len | input | 8 | Reply length, 1 to 128 |
| pkt_rd_addr | input | 4 | Capture buffer read address |
| sr_q | output | 8 | Shift register contents |
| sr_irq | output | 1 | Shift-register interrupt flag |
| treq_n | output | 1 | Transfer-request, active low |
| pkt_done | output | 1 | One-cycle pulse when a captured packet is handed off |
| pkt_len | output | 5 | Length of the last handed-off packet |
| pkt_rd_data | output | 8 | Capture buffer entry at pkt_rd_addr |

## Verification
Handshake edges are driven in several patterns. Stepping is tried with a transfer-in-progress edge alone, with an acknowledge edge alone, and with a write that repeats the previous value; these separate level-change detection from write detection. Transfer ends are tried with and without an acknowledge change, and with and without a reply waiting; these separate the idle toggle from the forced request. A packet of 18 bytes exposes the capture limit, and a one-byte reply exposes the last-byte request release.

// File: rtl/hs_shift_engine.sv
`timescale 1ns/1ps
module hs_shift_engine #(
  parameter int DW        = 8,
  parameter int OUT_DEPTH = 16,
  parameter int IN_DEPTH  = 128,
  parameter int TIP_BIT   = 5,
  parameter int TACK_BIT  = 4,
  parameter int DIR_BIT   = 4,
  localparam int OAW = $clog2(OUT_DEPTH),
  localparam int IAW = $clog2(IN_DEPTH),
  localparam int OCW = OAW + 1,
  localparam int ICW = IAW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_sel,
  input  logic [DW-1:0]  wr_data,
  input  logic           rd_sr,
  input  logic           rpl_we,
  input  logic [IAW-1:0] rpl_addr,
  input  logic [DW-1:0]  rpl_data,
  input  logic           rpl_go,
  input  logic [ICW-1:0] rpl_len,
  input  logic [OAW-1:0] pkt_rd_addr,
  output logic [DW-1:0]  sr_q,
  output logic           sr_irq,
  output logic           treq_n,
  output logic           pkt_done,
  output logic [OCW-1:0] pkt_len,
  output logic [DW-1:0]  pkt_rd_data
);

  logic [DW-1:0]  out_buf [OUT_DEPTH];
  logic [DW-1:0]  in_buf  [IN_DEPTH];
  logic           tip_n_q, tack_n_q, dir_q;
  logic [OCW-1:0] out_cnt;
  logic [ICW-1:0] in_idx, in_len;

  wire pb_wr     = wr_en && (wr_sel == 2'd0);
  wire sr_wr     = wr_en && (wr_sel == 2'd1);
  wire aux_wr    = wr_en && (wr_sel == 2'd2);
  wire new_tip_n = wr_data[TIP_BIT];
  wire new_tack  = wr_data[TACK_BIT];
  wire tack_flip = pb_wr && (new_tack != tack_n_q);
  wire hs_chg    = pb_wr && ((new_tip_n != tip_n_q) || (new_tack != tack_n_q));
  wire in_xfer   = pb_wr && !new_tip_n;
  wire pending   = in_idx < in_len;
  wire step_out  = in_xfer && hs_chg && dir_q;
  wire step_in   = in_xfer && hs_chg && !dir_q && pending;
  wire last_in   = step_in && ((in_idx + ICW'(1)) >= in_len);
  wire xfer_end  = pb_wr && new_tip_n && !tip_n_q;
  wire out_room  = out_cnt < OCW'(OUT_DEPTH);

  assign pkt_rd_data = out_buf[pkt_rd_addr];

  always_ff @(posedge clk) begin
    if (rpl_we) in_buf[rpl_addr] <= rpl_data;
    if (step_out && out_room) out_buf[out_cnt[OAW-1:0]] <= sr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tip_n_q  <= 1'b1;
      tack_n_q <= 1'b1;
      dir_q    <= 1'b0;
      sr_q     <= '0;
      sr_irq   <= 1'b0;
      treq_n   <= 1'b1;
      pkt_done <= 1'b0;
      pkt_len  <= '0;
      out_cnt  <= '0;
      in_idx   <= '0;
      in_len   <= '0;
    end else begin
      pkt_done <= 1'b0;
      if (pb_wr) begin
        tip_n_q  <= new_tip_n;
        tack_n_q <= new_tack;
      end
      if (aux_wr) dir_q <= wr_data[DIR_BIT];

      if (step_in) sr_q <= in_buf[in_idx[IAW-1:0]];
      else if (sr_wr) sr_q <= wr_data;

      if (step_out && out_room) out_cnt <= out_cnt + OCW'(1);
      else if (xfer_end && out_cnt != '0) begin
        pkt_done <= 1'b1;
        pkt_len  <= out_cnt;
        out_cnt  <= '0;
      end

      if (rpl_go) begin
        in_idx <= '0;
        in_len <= rpl_len;
      end else if (step_in) in_idx <= in_idx + ICW'(1);

      if (rpl_go) treq_n <= 1'b0;
      else if (last_in) treq_n <= 1'b1;
      else if (xfer_end) treq_n <= pending ? 1'b0 : (tack_flip ? ~treq_n : treq_n);

      if (step_out || step_in || xfer_end) sr_irq <= 1'b1;
      else if (sr_wr || rd_sr) sr_irq <= 1'b0;
    end
  end

  p_out_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= OCW'(OUT_DEPTH));

  p_in_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_idx <= in_len || in_len == '0);

  p_done_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> (pkt_len != '0 && pkt_len <= OCW'(OUT_DEPTH)));

  p_done_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> sr_irq);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_wr && new_tip_n && tip_n_q && !rpl_go) |=> ($stable(treq_n) && $stable(sr_q)));

  p_load_treq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rpl_go && rpl_len != '0) |=> !treq_n);

endmodule

// File: tb/hs_shift_engine_tb.sv
`timescale 1ns/1ps
module hs_shift_engine_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_sr = 0, rpl_we = 0, rpl_go = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0, rpl_data = 0, rpl_len = 0;
  logic [6:0] rpl_addr = 0;
  logic [3:0] pkt_rd_addr = 0;
  logic [7:0] sr_q, pkt_rd_data;
  logic sr_irq, treq_n, pkt_done;
  logic [4:0] pkt_len;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  hs_shift_engine u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sr(rd_sr), .rpl_we(rpl_we), .rpl_addr(rpl_addr), .rpl_data(rpl_data),
    .rpl_go(rpl_go), .rpl_len(rpl_len), .pkt_rd_addr(pkt_rd_addr),
    .sr_q(sr_q), .sr_irq(sr_irq), .treq_n(treq_n), .pkt_done(pkt_done),
    .pkt_len(pkt_len), .pkt_rd_data(pkt_rd_data));

  // {op, data, treq_n, sr_irq, pkt_done, sr_q}; op 0..2 write, 3 read strobe
  localparam logic [20:0] VEC [17] = '{
    {2'd2, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00},
    {2'd0, 8'h10, 1'b0, 1'b1, 1'b0, 8'hA1},
    {2'd3, 8'h00, 1'b0, 1'b0, 1'b0, 8'hA1},
    {2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 8'hB2},
    {2'd0, 8'h10, 1'b1, 1'b1, 1'b0, 8'hC3},
    {2'd0, 8'h10, 1'b1, 1'b1, 1'b0, 8'hC3},
    {2'd3, 8'h00, 1'b1, 1'b0, 1'b0, 8'hC3},
    {2'd0, 8'h30, 1'b1, 1'b1, 1'b0, 8'hC3},
    {2'd1, 8'h5A, 1'b1, 1'b0, 1'b0, 8'h5A},
    {2'd2, 8'h10, 1'b1, 1'b0, 1'b0, 8'h5A},
    {2'd0, 8'h10, 1'b1, 1'b1, 1'b0, 8'h5A},
    {2'd1, 8'h6B, 1'b1, 1'b0, 1'b0, 8'h6B},
    {2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h6B},
    {2'd0, 8'h30, 1'b0, 1'b1, 1'b1, 8'h6B},
    {2'd0, 8'h20, 1'b0, 1'b1, 1'b0, 8'h6B},
    {2'd0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h6B},
    {2'd0, 8'h30, 1'b1, 1'b1, 1'b1, 8'h6B}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] kind, input logic [7:0] d);
    @(negedge clk);
    if (kind == 2'd3) rd_sr = 1'b1;
    else begin wr_en = 1'b1; wr_sel = kind; wr_data = d; end
    @(negedge clk);
    wr_en = 1'b0; rd_sr = 1'b0;
  endtask

  task automatic load_byte(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    rpl_we = 1'b1; rpl_addr = a; rpl_data = d;
    @(negedge clk);
    rpl_we = 1'b0;
  endtask

  task automatic arm(input logic [7:0] n);
    @(negedge clk);
    rpl_go = 1'b1; rpl_len = n;
    @(negedge clk);
    rpl_go = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 treq_n", treq_n, 1);
    check("R1 sr_irq", sr_irq, 0);
    check("R1 sr_q", sr_q, 0);
    check("R1 pkt_done", pkt_done, 0);

    load_byte(7'd0, 8'hA1);
    load_byte(7'd1, 8'hB2);
    load_byte(7'd2, 8'hC3);
    arm(8'd3);
    check("R10 treq after arm", treq_n, 0);

    // R2 R3 R5 R7 R8 R9 table walk
    for (int i = 0; i < 17; i++) begin
      op(VEC[i][20:19], VEC[i][18:11]);
      check($sformatf("R2/R5/R8 treq_n vec%0d", i), treq_n, VEC[i][10]);
      check($sformatf("R7 sr_irq vec%0d", i), sr_irq, VEC[i][9]);
      check($sformatf("R6 pkt_done vec%0d", i), pkt_done, VEC[i][8]);
      check($sformatf("R3/R5/R9 sr_q vec%0d", i), sr_q, VEC[i][7:0]);
    end
    pkt_rd_addr = 4'd0;
    #1;
    check("R6 pkt_len", pkt_len, 1);
    check("R3 captured byte", pkt_rd_data, 8'h6B);

    // R4 overflow: 18 steps, first 16 kept
    for (int i = 0; i < 18; i++) begin
      op(2'd1, 8'h10 + 8'(i));
      op(2'd0, (i % 2 == 0) ? 8'h10 : 8'h00);
    end
    op(2'd0, 8'h30);
    check("R6 done after overflow", pkt_done, 1);
    check("R4 length capped", pkt_len, 16);
    pkt_rd_addr = 4'd0;
    #1;
    check("R3 first entry", pkt_rd_data, 8'h10);
    pkt_rd_addr = 4'd15;
    #1;
    check("R4 last kept entry", pkt_rd_data, 8'h1F);

    // R8 pending reply forces request at end despite ack toggle
    load_byte(7'd0, 8'hC4);
    arm(8'd1);
    check("R10 treq one-byte arm", treq_n, 0);
    op(2'd0, 8'h10);
    op(2'd0, 8'h00);
    op(2'd0, 8'h30);
    check("R8 pending forces treq", treq_n, 0);
    check("R6 done two bytes", pkt_len, 2);

    // R5 one-byte reply releases request after delivery
    op(2'd2, 8'h00);
    op(2'd0, 8'h10);
    check("R5 byte delivered", sr_q, 8'hC4);
    check("R5 treq after last", treq_n, 1);
    op(2'd0, 8'h00);
    check("R5 no step when empty", sr_q, 8'hC4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule